// File: doc/BRIEF.md
# Interrupt Line State Register Bank

This block holds three flags for each interrupt line: enabled, pending and active. It exposes them to software through a small register bus with an address, write data, a write strobe, a read strobe and read data. The enable flags and the pending flags each have two windows. One window sets bits and the other clears them. In both, a 1 in the write data acts on its line and a 0 leaves the line alone, so software can change a single line without reading the word first. The active flags sit in a read-only window, and hardware owns them.

The address space is laid out for 96 lines, in three 32-bit words per window. Only the lowest 82 lines are built. A rising edge on a line's request input makes that line pending. A handler-entry strobe with a line number clears that line's pending flag and sets its active flag. A handler-exit strobe clears the active flag. The bank drives the full enable vector, the full pending vector and their per-line AND to a downstream priority arbiter.

Top module: `irq_state_bank`

## Requirements
- R1: The bus address is {window[2:0], word[1:0]}. Window codes: 0 set-enable, 1 clear-enable, 2 set-pending, 3 clear-pending, 4 active. Bit k of word n in any window belongs to line 32*n+k.
- R2: A write to the set-enable window enables every line whose data bit is 1. A 0 bit leaves its line unchanged.
- R3: A write to the clear-enable window disables every line whose data bit is 1. A 0 bit leaves its line unchanged.
- R4: Writes to the set-pending and clear-pending windows set and clear pending flags with the same write-one rule.
- R5: Lines 82 to 95 do not exist. Bits 18 to 31 of word 2 read as zero and ignore writes. Word 3 of every window reads as zero and ignores writes.
- R6: Reading the set window and the clear window of one state returns the same current value.
- R7: A 0-to-1 change on a request input sets that line's pending flag. A request that stays high does not set the flag again after it has been cleared.
- R8: A handler-entry strobe for line L clears pending[L] and sets active[L] in the same cycle. A handler-exit strobe for L clears active[L]. Line numbers of 82 or more are ignored.
- R9: Writes to the active window (code 4) change nothing.
- R10: When a pending flag is cleared and set in the same cycle (a software clear together with a software or hardware set), the clear wins.
- R11: After reset, all enable, pending and active flags are 0.
- R12: `enable_o`, `pending_o` and `ready_o` show the current flags. `ready_o` is enable AND pending, line by line.
- R13: `bus_rdata_o` holds the addressed word one cycle after `bus_rd_i` is sampled high, and keeps that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | 5 | {window code, word index} |
| bus_wdata_i | input | 32 | Write data, one bit per line |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Registered read data |
| irq_req_i | input | 82 | Request inputs, edge-detected |
| enter_vld_i | input | 1 | Handler-entry strobe |
| enter_id_i | input | 7 | Line number for handler entry |
| exit_vld_i | input | 1 | Handler-exit strobe |
| exit_id_i | input | 7 | Line number for handler exit |
| enable_o | output | 82 | Enable flags |
| pending_o | output | 82 | Pending flags |
| ready_o | output | 82 | Enable AND pending, per line |

## Verification
The enable and pending windows are swept with a single-bit write for every one of the 82 lines. Each write is read back through both the set window and the clear window, which separates a wrong line-to-bit mapping from a wrong window decode. Alternating-bit and all-ones clear patterns, together with all-zero writes, tell the write-one rule apart from a plain overwrite. All-ones writes to word 2 and word 3 expose any storage above line 81. A request edge is placed in the same cycle as a software clear, and a request is held high across a clear, to separate edge capture from level capture and to show which side wins a conflict. Handler entry and exit are tried on boundary lines and on an out-of-range number.

// File: rtl/nvb_pkg.sv
package nvb_pkg;

    localparam int WORD_W = 32;
    localparam int WIN_W  = 3;

    typedef enum logic [WIN_W-1:0] {
        WIN_SET_EN = 3'd0,
        WIN_CLR_EN = 3'd1,
        WIN_SET_PD = 3'd2,
        WIN_CLR_PD = 3'd3,
        WIN_ACTIVE = 3'd4
    } win_e;

endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode import nvb_pkg::*; #(
    parameter int NUM_LINES = 82,
    parameter int WSEL_W    = 2
) (
    input  logic                 wr_i,
    input  logic [WIN_W-1:0]     win_i,
    input  logic [WSEL_W-1:0]    word_i,
    input  logic [WORD_W-1:0]    wdata_i,
    output logic [NUM_LINES-1:0] en_set_o,
    output logic [NUM_LINES-1:0] en_clr_o,
    output logic [NUM_LINES-1:0] pd_set_o,
    output logic [NUM_LINES-1:0] pd_clr_o
);

    // One strobe per line per window; lines past NUM_LINES have no decoder.
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        localparam int WI = i / WORD_W;
        localparam int BI = i % WORD_W;
        logic hit;
        assign hit         = wr_i && (int'(word_i) == WI) && wdata_i[BI];
        assign en_set_o[i] = hit && (win_i == WIN_SET_EN);
        assign en_clr_o[i] = hit && (win_i == WIN_CLR_EN);
        assign pd_set_o[i] = hit && (win_i == WIN_SET_PD);
        assign pd_clr_o[i] = hit && (win_i == WIN_CLR_PD);
    end

endmodule

// File: rtl/irq_bank_edge.sv
module irq_bank_edge #(
    parameter int NUM_LINES = 82
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_LINES-1:0] req_i,
    output logic [NUM_LINES-1:0] rise_o
);

    logic [NUM_LINES-1:0] req_d, req_q;

    always_comb begin
        req_d = req_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) req_q <= '0;
        else         req_q <= req_d;
    end

    assign rise_o = req_i & ~req_q;

endmodule

// File: rtl/irq_bank_rdmux.sv
module irq_bank_rdmux import nvb_pkg::*; #(
    parameter int NUM_LINES = 82,
    parameter int WSEL_W    = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 rd_i,
    input  logic [WIN_W-1:0]     win_i,
    input  logic [WSEL_W-1:0]    word_i,
    input  logic [NUM_LINES-1:0] enable_i,
    input  logic [NUM_LINES-1:0] pending_i,
    input  logic [NUM_LINES-1:0] active_i,
    output logic [WORD_W-1:0]    rdata_o
);

    localparam int NUM_WORDS = (NUM_LINES + WORD_W - 1) / WORD_W;
    localparam int PAD_W     = NUM_WORDS * WORD_W;
    localparam int TAIL_W    = NUM_LINES - (NUM_WORDS - 1) * WORD_W;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
        logic              last;
    } rd_state_t;

    rd_state_t         rd_d, rd_q;
    logic [PAD_W-1:0]  sel_pad;
    logic [WORD_W-1:0] word_val;

    always_comb begin
        sel_pad = '0;
        case (win_i)
            WIN_SET_EN, WIN_CLR_EN: sel_pad[NUM_LINES-1:0] = enable_i;
            WIN_SET_PD, WIN_CLR_PD: sel_pad[NUM_LINES-1:0] = pending_i;
            WIN_ACTIVE:             sel_pad[NUM_LINES-1:0] = active_i;
            default:                sel_pad = '0;
        endcase
        word_val = '0;
        if (int'(word_i) < NUM_WORDS) begin
            word_val = sel_pad[int'(word_i)*WORD_W +: WORD_W];
        end
        rd_d = rd_q;
        if (rd_i) begin
            rd_d.rdata = word_val;
            rd_d.last  = (int'(word_i) == NUM_WORDS - 1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) rd_q <= '0;
        else         rd_q <= rd_d;
    end

    assign rdata_o = rd_q.rdata;

    AST_TAIL_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_q.last |-> ((rd_q.rdata >> TAIL_W) == '0)); // R5

    AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_i |=> $stable(rdata_o)); // R13

endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank import nvb_pkg::*; #(
    parameter  int NUM_LINES = 82,
    localparam int NUM_WORDS = (NUM_LINES + WORD_W - 1) / WORD_W,
    localparam int WSEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS + 1) : 1,
    localparam int ADDR_W    = WIN_W + WSEL_W,
    localparam int ID_W      = $clog2(NUM_LINES)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [WORD_W-1:0]    bus_wdata_i,
    input  logic                 bus_wr_i,
    input  logic                 bus_rd_i,
    output logic [WORD_W-1:0]    bus_rdata_o,
    input  logic [NUM_LINES-1:0] irq_req_i,
    input  logic                 enter_vld_i,
    input  logic [ID_W-1:0]      enter_id_i,
    input  logic                 exit_vld_i,
    input  logic [ID_W-1:0]      exit_id_i,
    output logic [NUM_LINES-1:0] enable_o,
    output logic [NUM_LINES-1:0] pending_o,
    output logic [NUM_LINES-1:0] ready_o
);

    typedef struct packed {
        logic [NUM_LINES-1:0] enable;
        logic [NUM_LINES-1:0] pending;
        logic [NUM_LINES-1:0] active;
    } line_state_t;

    line_state_t st_d, st_q;

    logic [WIN_W-1:0]     win;
    logic [WSEL_W-1:0]    word;
    logic [NUM_LINES-1:0] en_set, en_clr, pd_set, pd_clr;
    logic [NUM_LINES-1:0] rise, enter_mask, exit_mask;

    assign win  = bus_addr_i[ADDR_W-1 -: WIN_W];
    assign word = bus_addr_i[WSEL_W-1:0];

    irq_bank_decode #(.NUM_LINES(NUM_LINES), .WSEL_W(WSEL_W)) u_decode (
        .wr_i     (bus_wr_i),
        .win_i    (win),
        .word_i   (word),
        .wdata_i  (bus_wdata_i),
        .en_set_o (en_set),
        .en_clr_o (en_clr),
        .pd_set_o (pd_set),
        .pd_clr_o (pd_clr)
    );

    irq_bank_edge #(.NUM_LINES(NUM_LINES)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_i  (irq_req_i),
        .rise_o (rise)
    );

    irq_bank_rdmux #(.NUM_LINES(NUM_LINES), .WSEL_W(WSEL_W)) u_rdmux (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rd_i      (bus_rd_i),
        .win_i     (win),
        .word_i    (word),
        .enable_i  (st_q.enable),
        .pending_i (st_q.pending),
        .active_i  (st_q.active),
        .rdata_o   (bus_rdata_o)
    );

    // Handler strobes: out-of-range line numbers select nothing.
    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            enter_mask[i] = enter_vld_i && (int'(enter_id_i) == i);
            exit_mask[i]  = exit_vld_i  && (int'(exit_id_i)  == i);
        end
    end

    always_comb begin
        st_d         = st_q;
        st_d.enable  = (st_q.enable | en_set) & ~en_clr;
        // Clears (software or handler entry) dominate every set source.
        st_d.pending = (st_q.pending | pd_set | rise) & ~pd_clr & ~enter_mask;
        st_d.active  = (st_q.active & ~exit_mask) | enter_mask;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign enable_o  = st_q.enable;
    assign pending_o = st_q.pending;
    assign ready_o   = st_q.enable & st_q.pending;

    AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|pd_clr) |=> ((st_q.pending & $past(pd_clr)) == '0)); // R10

    AST_ENTRY_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|enter_mask) |=> (((st_q.active & $past(enter_mask)) == $past(enter_mask))
                           && ((st_q.pending & $past(enter_mask)) == '0))); // R8

    AST_EXIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|exit_mask) && !enter_vld_i) |=> ((st_q.active & $past(exit_mask)) == '0)); // R8

    AST_ENABLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_wr_i && (win == WIN_SET_EN || win == WIN_CLR_EN)) |=> $stable(st_q.enable)); // R2

    AST_ACTIVE_HW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!enter_vld_i && !exit_vld_i) |=> $stable(st_q.active)); // R9

    AST_EDGE_PENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(rise & ~pd_clr & ~enter_mask)) |=>
        ((st_q.pending & $past(rise & ~pd_clr & ~enter_mask)) == $past(rise & ~pd_clr & ~enter_mask))); // R7

endmodule

// File: tb/test_irq_state_bank.sv
module test_irq_state_bank;

    localparam int N = 82;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr = 0, rd = 0;
    logic [31:0] rdata;
    logic [N-1:0] irq = '0;
    logic        enter_vld = 0, exit_vld = 0;
    logic [6:0]  enter_id = '0, exit_id = '0;
    logic [N-1:0] enable_o, pending_o, ready_o;

    logic [N-1:0] m_en = '0, m_pd = '0, m_act = '0;
    int tests = 0, fails = 0;

    always #4 clk = ~clk;

    irq_state_bank i_irq_state_bank (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_rdata_o(rdata), .irq_req_i(irq),
        .enter_vld_i(enter_vld), .enter_id_i(enter_id), .exit_vld_i(exit_vld),
        .exit_id_i(exit_id), .enable_o(enable_o), .pending_o(pending_o), .ready_o(ready_o)
    );

    function automatic logic [31:0] word_of(input logic [N-1:0] v, input int w);
        logic [127:0] p;
        p = '0;
        p[N-1:0] = v;
        return p[w*32 +: 32];
    endfunction

    task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chkv(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input int win, input int word, input logic [31:0] d);
        @(negedge clk);
        addr = {3'(win), 2'(word)}; wdata = d; wr = 1;
        @(negedge clk);
        wr = 0;
    endtask

    task automatic bus_read(input int win, input int word, output logic [31:0] d);
        @(negedge clk);
        addr = {3'(win), 2'(word)}; rd = 1;
        @(negedge clk);
        rd = 0;
        d = rdata;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        logic [N-1:0] src;
        for (int win = 0; win < 5; win++) begin
            src = (win < 2) ? m_en : (win < 4) ? m_pd : m_act;
            for (int w = 0; w < 4; w++) begin
                bus_read(win, w, v);
                chk32(tag, v, word_of(src, w));
            end
        end
        chkv({tag, " enable_o"}, enable_o, m_en);
        chkv({tag, " pending_o"}, pending_o, m_pd);
        chkv({tag, " ready_o R12"}, ready_o, m_en & m_pd);
    endtask

    task automatic strobe_entry(input int id);
        @(negedge clk); enter_vld = 1; enter_id = 7'(id);
        @(negedge clk); enter_vld = 0;
    endtask

    task automatic strobe_exit(input int id);
        @(negedge clk); exit_vld = 1; exit_id = 7'(id);
        @(negedge clk); exit_vld = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, held;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R11 reset state
        check_all("R11 reset");

        // R1 R2 R6: per-line set-enable sweep
        for (int l = 0; l < N; l++) begin
            bus_write(0, l / 32, 32'h1 << (l % 32));
            m_en[l] = 1'b1;
            bus_read(0, l / 32, v);
            chk32("R1 R2 set-window", v, word_of(m_en, l / 32));
            bus_read(1, l / 32, v);
            chk32("R6 clear-window read", v, word_of(m_en, l / 32));
            chkv("R2 enable_o", enable_o, m_en);
        end
        bus_write(0, 1, 32'h0);
        check_all("R2 zero write");

        // R3 alternating then full clear
        for (int w = 0; w < 3; w++) bus_write(1, w, 32'h5555_5555);
        for (int l = 0; l < N; l++) if ((l % 2) == 0) m_en[l] = 1'b0;
        check_all("R3 alternate");
        for (int w = 0; w < 4; w++) bus_write(1, w, 32'hFFFF_FFFF);
        m_en = '0;
        check_all("R3 full");

        // R5 upper bits and word 3
        bus_write(0, 2, 32'hFFFF_FFFF);
        m_en[81:64] = '1;
        bus_read(0, 2, v);
        chk32("R5 word2 tail", v, 32'h0003_FFFF);
        bus_write(0, 3, 32'hFFFF_FFFF);
        bus_read(1, 3, v);
        chk32("R5 word3", v, 32'h0);
        chkv("R5 enable_o", enable_o, m_en);
        bus_write(1, 2, 32'hFFFF_FFFF);
        m_en = '0;

        // R4 R1 pending sweep
        for (int l = 0; l < N; l++) begin
            bus_write(2, l / 32, 32'h1 << (l % 32));
            m_pd[l] = 1'b1;
            chkv("R4 set-pending", pending_o, m_pd);
            bus_read(3, l / 32, v);
            chk32("R4 R6 pending read", v, word_of(m_pd, l / 32));
            bus_write(3, l / 32, 32'h1 << (l % 32));
            m_pd[l] = 1'b0;
            chkv("R4 clear-pending", pending_o, m_pd);
        end

        // R9 active window ignores writes
        for (int w = 0; w < 4; w++) bus_write(4, w, 32'hFFFF_FFFF);
        check_all("R9 active write");

        // R7 request edges, held level after clear
        foreach (m_pd[l]) begin
            if (l == 0 || l == 31 || l == 32 || l == 63 || l == 64 || l == 81) begin
                @(negedge clk); irq[l] = 1'b1;
                @(negedge clk);
                m_pd[l] = 1'b1;
                chkv("R7 edge sets", pending_o, m_pd);
                bus_write(3, l / 32, 32'h1 << (l % 32));
                m_pd[l] = 1'b0;
                repeat (3) @(negedge clk);
                chkv("R7 held level", pending_o, m_pd);
                irq[l] = 1'b0;
                @(negedge clk);
            end
        end

        // R10 clear in same cycle as edge
        @(negedge clk);
        irq[10] = 1'b1; irq[11] = 1'b1;
        addr = {3'd3, 2'd0}; wdata = 32'h1 << 10; wr = 1;
        @(negedge clk);
        wr = 0;
        m_pd[11] = 1'b1;
        chkv("R10 clear wins", pending_o, m_pd);
        bus_write(3, 0, 32'h0000_0C00);
        m_pd[11] = 1'b0;
        irq[10] = 1'b0; irq[11] = 1'b0;
        chkv("R10 cleanup", pending_o, m_pd);

        // R8 handler entry and exit
        bus_write(2, 0, 32'h1 << 5);
        bus_write(2, 1, 32'h1 << 8);
        m_pd[5] = 1'b1; m_pd[40] = 1'b1;
        strobe_entry(5);
        m_pd[5] = 1'b0; m_act[5] = 1'b1;
        check_all("R8 entry");
        strobe_entry(81);
        m_act[81] = 1'b1;
        strobe_entry(90);
        check_all("R8 entry boundary/out-of-range");
        strobe_exit(5);
        m_act[5] = 1'b0;
        strobe_exit(95);
        check_all("R8 exit");
        strobe_exit(81);
        m_act[81] = 1'b0;
        chkv("R8 exit 81", pending_o, m_pd);
        bus_read(4, 2, v);
        chk32("R8 active word2", v, 32'h0);

        // R12 ready mix
        bus_write(0, 0, 32'h0000_FFFF);
        bus_write(2, 0, 32'h00FF_00F0);
        for (int l = 0; l < 16; l++) m_en[l] = 1'b1;
        for (int l = 0; l < 32; l++) if (((32'h00FF_00F0 >> l) & 1) != 0) m_pd[l] = 1'b1;
        check_all("R12 ready");

        // R13 read data hold
        bus_read(0, 0, held);
        chk32("R13 read", held, 32'h0000_FFFF);
        bus_write(1, 0, 32'hFFFF_FFFF);
        for (int l = 0; l < 32; l++) m_en[l] = 1'b0;
        repeat (3) @(negedge clk);
        chk32("R13 hold", rdata, held);
        check_all("R13 final");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule